// File: doc/BRIEF.md
# Two-Stage Masked Pattern Trigger

This block watches one of sixteen 64-bit candidate vectors and raises a one-cycle trigger pulse when a two-step pattern appears on that vector. A capture engine uses the pulse to start storing samples. A 4-bit select picks the watched vector, and the select defaults to 0. A shared bit mask marks which bit positions take part in the comparison.

A capture command arms the block in its first step. In the first step, a sample that matches the first compare vector on all masked bits moves the block to the second step. In the second step, the next counted sample must match the second compare vector. If it does, the pulse fires and the block goes idle. If it does not, the block returns to the first step.

A sample counts only when the valid strobe of the selected vector is high, or when the ignore-valid input is set. A cancel command stops the search at once.

Top module: `pattern_seq_trigger`

## Requirements
- R1: After reset the block is idle. It never pulses `trigPulse` until a capture command has been given, even when the pattern is present.
- R2: Only the vector whose index equals `trigSel` is compared. Index 0 is the vector in bits 63:0 of `candData`, and index i is the vector in bits 64*i+63 to 64*i.
- R3: A step matches when the watched vector agrees with the compare vector at every bit where `bitMask` is 1. Bits where the mask is 0 are not compared.
- R4: In the first step, a counted sample that matches `cmpFirst` moves the block to the second step. In the second step, a counted sample that matches `cmpSecond` makes `trigPulse` high for exactly one cycle, in the cycle after the clock edge on which that sample was taken.
- R5: In the second step, a counted sample that does not match `cmpSecond` returns the block to the first step. That sample is not compared with `cmpFirst`.
- R6: A sample counts only when `candValid[trigSel]` is 1 or `ignoreValid` is 1. Samples that do not count leave the step unchanged.
- R7: After a pulse the block stays idle until the next capture command.
- R8: `cancelCmd` returns the block to idle and suppresses any pulse that a match in the same cycle would have caused. It also wins over `captureCmd` in the same cycle.
- R9: A capture command in any state restarts the search in the first step. A match in the same cycle is not used.
- R10: With the mask and both compare vectors all zeros, and samples counting every cycle, a capture on edge k yields the pulse after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| candData | input | 1024 | Sixteen candidate vectors, packed with index 0 in the low bits |
| candValid | input | 16 | Valid strobe for each candidate vector |
| ignoreValid | input | 1 | When 1, every cycle counts as a sample |
| trigSel | input | 4 | Index of the watched vector |
| cmpFirst | input | 64 | Compare vector for the first step |
| cmpSecond | input | 64 | Compare vector for the second step |
| bitMask | input | 64 | 1 marks a bit position that is compared |
| captureCmd | input | 1 | Arms the search in the first step |
| cancelCmd | input | 1 | Stops the search |
| trigPulse | output | 1 | One-cycle trigger pulse |

## Verification
Cancel and a completing second-step match can fall in the same cycle. The bench provokes this by raising `cancelCmd` on exactly the sample that would finish the sequence, and it judges the case by the absence of a pulse on the next cycle. Capture and a match can also coincide. The bench asserts capture on a second-step match and expects the search to restart in the first step, with no pulse.

Random phases drive patterns with matches mixed in, sparse masks, and gaps in the valid strobes. The bench compares each output cycle against a step model that it keeps itself.

// File: rtl/ptrig_pkg.sv
`timescale 1ns/1ps
package ptrig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } trig_state_t;

  // strobes handed from the compare datapath to the step control
  typedef struct packed {
    logic sampleEn;
    logic hitFirst;
    logic hitSecond;
  } cmp_strobe_t;
endpackage

// File: rtl/ptrig_match.sv
`timescale 1ns/1ps
module ptrig_match
  import ptrig_pkg::*;
#(
  parameter int NUM_IN = 16,
  parameter int DATA_W = 64,
  localparam int SEL_W = $clog2(NUM_IN)
) (
  input  logic [NUM_IN*DATA_W-1:0] candData,
  input  logic [NUM_IN-1:0]        candValid,
  input  logic                     ignoreValid,
  input  logic [SEL_W-1:0]         trigSel,
  input  logic [DATA_W-1:0]        cmpFirst,
  input  logic [DATA_W-1:0]        cmpSecond,
  input  logic [DATA_W-1:0]        bitMask,
  output cmp_strobe_t              strobes
);
  logic [DATA_W-1:0] vecArr [NUM_IN];
  logic [DATA_W-1:0] watched;

  genvar g;
  generate
    for (g = 0; g < NUM_IN; g++) begin : g_unpack
      assign vecArr[g] = candData[g*DATA_W +: DATA_W];
    end
  endgenerate

  assign watched = vecArr[trigSel];

  always_comb begin
    strobes.sampleEn  = ignoreValid | candValid[trigSel];
    strobes.hitFirst  = ~|((watched ^ cmpFirst) & bitMask);
    strobes.hitSecond = ~|((watched ^ cmpSecond) & bitMask);
  end
endmodule

// File: rtl/ptrig_ctrl.sv
`timescale 1ns/1ps
module ptrig_ctrl
  import ptrig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        captureCmd,
  input  logic        cancelCmd,
  input  cmp_strobe_t strobes,
  output logic        trigPulse
);
  trig_state_t stepQ, stepD;
  logic        pulseD;

  always_comb begin
    stepD  = stepQ;
    pulseD = 1'b0;
    if (cancelCmd) begin
      stepD = ST_IDLE;
    end else if (captureCmd) begin
      stepD = ST_FIRST;
    end else if (strobes.sampleEn) begin
      unique case (stepQ)
        ST_FIRST:  if (strobes.hitFirst) stepD = ST_SECOND;
        ST_SECOND: begin
          if (strobes.hitSecond) begin
            pulseD = 1'b1;
            stepD  = ST_IDLE;
          end else begin
            stepD = ST_FIRST;
          end
        end
        default:   stepD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ     <= ST_IDLE;
      trigPulse <= 1'b0;
    end else begin
      stepQ     <= stepD;
      trigPulse <= pulseD;
    end
  end
endmodule

// File: rtl/pattern_seq_trigger.sv
`timescale 1ns/1ps
module pattern_seq_trigger
  import ptrig_pkg::*;
#(
  parameter int NUM_IN = 16,
  parameter int DATA_W = 64,
  localparam int SEL_W = $clog2(NUM_IN)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN*DATA_W-1:0] candData,
  input  logic [NUM_IN-1:0]        candValid,
  input  logic                     ignoreValid,
  input  logic [SEL_W-1:0]         trigSel,
  input  logic [DATA_W-1:0]        cmpFirst,
  input  logic [DATA_W-1:0]        cmpSecond,
  input  logic [DATA_W-1:0]        bitMask,
  input  logic                     captureCmd,
  input  logic                     cancelCmd,
  output logic                     trigPulse
);
  cmp_strobe_t strobes;

  ptrig_match #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_match (
    .candData   (candData),
    .candValid  (candValid),
    .ignoreValid(ignoreValid),
    .trigSel    (trigSel),
    .cmpFirst   (cmpFirst),
    .cmpSecond  (cmpSecond),
    .bitMask    (bitMask),
    .strobes    (strobes)
  );

  ptrig_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .captureCmd(captureCmd),
    .cancelCmd (cancelCmd),
    .strobes   (strobes),
    .trigPulse (trigPulse)
  );
endmodule

// File: rtl/ptrig_chk.sv
`timescale 1ns/1ps
module ptrig_chk #(
  parameter int NUM_IN = 16,
  parameter int DATA_W = 64,
  localparam int SEL_W = $clog2(NUM_IN)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_IN*DATA_W-1:0] candData,
  input logic [NUM_IN-1:0]        candValid,
  input logic                     ignoreValid,
  input logic [SEL_W-1:0]         trigSel,
  input logic [DATA_W-1:0]        cmpSecond,
  input logic [DATA_W-1:0]        bitMask,
  input logic                     captureCmd,
  input logic                     cancelCmd,
  input logic                     trigPulse
);
  logic [DATA_W-1:0] seenVec;
  logic              secondOk;
  logic              countedNow;
  assign seenVec    = candData[trigSel*DATA_W +: DATA_W];
  assign secondOk   = ((seenVec ^ cmpSecond) & bitMask) == '0;
  assign countedNow = ignoreValid | candValid[trigSel];

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R8
  cancel_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    cancelCmd |=> !trigPulse);

  // R9
  capture_restarts_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureCmd |=> !trigPulse);

  // R6
  counted_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    !countedNow |=> !trigPulse);

  // R3
  second_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    !secondOk |=> !trigPulse);
endmodule

bind pattern_seq_trigger ptrig_chk #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .candData   (candData),
  .candValid  (candValid),
  .ignoreValid(ignoreValid),
  .trigSel    (trigSel),
  .cmpSecond  (cmpSecond),
  .bitMask    (bitMask),
  .captureCmd (captureCmd),
  .cancelCmd  (cancelCmd),
  .trigPulse  (trigPulse)
);

// File: tb/sim_pattern_seq_trigger.sv
`timescale 1ns/1ps
module sim_pattern_seq_trigger;
  localparam int N = 16;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] cand [N];
  logic [N*W-1:0] candData;
  logic [N-1:0] candValid = '0;
  logic         ignoreValid = 1'b0;
  logic [3:0]   trigSel = 4'd0;
  logic [W-1:0] cmpFirst = '0, cmpSecond = '0, bitMask = '0;
  logic         captureCmd = 1'b0, cancelCmd = 1'b0;
  logic         trigPulse;

  int checks = 0;
  int errors = 0;
  int mStep = 0;  // 0 idle, 1 first step, 2 second step
  logic expPulse = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) candData[i*W +: W] = cand[i];

  pattern_seq_trigger u0 (
    .clk(clk), .rstN(rstN), .candData(candData), .candValid(candValid),
    .ignoreValid(ignoreValid), .trigSel(trigSel), .cmpFirst(cmpFirst),
    .cmpSecond(cmpSecond), .bitMask(bitMask), .captureCmd(captureCmd),
    .cancelCmd(cancelCmd), .trigPulse(trigPulse)
  );

  function automatic logic maskHit(logic [W-1:0] d, logic [W-1:0] c, logic [W-1:0] m);
    return ((d ^ c) & m) == '0;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s trigPulse actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // model the edge from current inputs, advance one cycle, compare
  task automatic cyc(string tag);
    logic cnt;
    cnt = ignoreValid | candValid[trigSel];
    expPulse = 1'b0;
    if (cancelCmd) mStep = 0;
    else if (captureCmd) mStep = 1;
    else if (cnt) begin
      if (mStep == 1) begin
        if (maskHit(cand[trigSel], cmpFirst, bitMask)) mStep = 2;
      end else if (mStep == 2) begin
        if (maskHit(cand[trigSel], cmpSecond, bitMask)) begin
          expPulse = 1'b1; mStep = 0;
        end else mStep = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, trigPulse, expPulse);
    captureCmd = 1'b0;
    cancelCmd  = 1'b0;
  endtask

  task automatic fillRandom();
    for (int i = 0; i < N; i++) cand[i] = {$urandom, $urandom};
  endtask

  initial begin
    #750000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) cand[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", trigPulse, 1'b0);
    rstN = 1'b1;
    ignoreValid = 1'b1;
    // R1: pattern trivially present but no capture
    repeat (4) cyc("R1 no capture");

    // R10: defaults, pulse two samples after capture
    captureCmd = 1'b1; cyc("R10 capture edge");
    cyc("R10 first sample");
    cyc("R10 pulse");
    check("R10 pulse seen", trigPulse, 1'b1);
    // R7: idle afterwards
    repeat (3) cyc("R7 idle after pulse");

    // R2/R3: selected vector and masked compare
    bitMask = 64'h0000_FFFF_0000_00FF;
    cmpFirst = 64'h1234_5678_9ABC_DEF0;
    cmpSecond = 64'h0F0F_A5A5_0000_0011;
    trigSel = 4'd5;
    fillRandom();
    captureCmd = 1'b1; cyc("R9 arm");
    cand[3] = cmpFirst; cand[5] = ~cmpFirst; cyc("R2 other index matches");
    cand[5] = cmpFirst ^ 64'hFFFF_0000_FFFF_FF00; cyc("R3 unmasked bits differ");
    cand[5] = {$urandom, $urandom} & ~bitMask | cmpSecond & bitMask; cyc("R3 second masked");
    check("R3 pulse", trigPulse, 1'b1);

    // R5: second step mismatch returns to first step; that sample not reused
    captureCmd = 1'b1; cyc("R5 arm");
    cand[5] = cmpFirst; cyc("R5 first hit");
    cand[5] = cmpFirst; cyc("R5 mismatch in second");
    cand[5] = cmpSecond; cyc("R5 back in first");
    cand[5] = cmpFirst; cyc("R5 first hit again");
    cand[5] = cmpSecond; cyc("R5 completes");
    check("R5 pulse", trigPulse, 1'b1);

    // R6: valid gating
    ignoreValid = 1'b0;
    candValid = '0;
    captureCmd = 1'b1; cyc("R6 arm");
    cand[5] = cmpFirst; cyc("R6 invalid first");
    candValid[5] = 1'b1; cyc("R6 valid first");
    candValid[5] = 1'b0; cand[5] = cmpSecond; candValid[4] = 1'b1; cyc("R6 gap keeps step");
    check("R6 no pulse on gap", trigPulse, 1'b0);
    candValid[5] = 1'b1; cyc("R6 valid second");
    check("R6 pulse", trigPulse, 1'b1);

    // R8: cancel together with completing match
    captureCmd = 1'b1; cyc("R8 arm");
    cand[5] = cmpFirst; cyc("R8 first hit");
    cand[5] = cmpSecond; cancelCmd = 1'b1; captureCmd = 1'b1; cyc("R8 cancel wins");
    check("R8 no pulse", trigPulse, 1'b0);
    cand[5] = cmpFirst; cyc("R8 stays idle");
    cand[5] = cmpSecond; cyc("R8 stays idle 2");

    // R9: capture on a completing match restarts
    captureCmd = 1'b1; cyc("R9 arm");
    cand[5] = cmpFirst; cyc("R9 first hit");
    cand[5] = cmpSecond; captureCmd = 1'b1; cyc("R9 restart");
    check("R9 no pulse", trigPulse, 1'b0);
    cand[5] = cmpFirst; cyc("R9 first again");
    cand[5] = cmpSecond; cyc("R9 completes");

    // R4: random phase
    for (int r = 0; r < 3000; r++) begin
      if ((r % 400) == 0) begin
        trigSel   = 4'($urandom);
        bitMask   = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        cmpFirst  = {$urandom, $urandom};
        cmpSecond = {$urandom, $urandom};
      end
      fillRandom();
      case ($urandom % 4)
        0: cand[trigSel] = cmpFirst;
        1: cand[trigSel] = cmpSecond;
        default: ;
      endcase
      candValid   = N'($urandom) | N'($urandom);
      ignoreValid = ($urandom % 8) == 0;
      captureCmd  = ($urandom % 10) == 0;
      cancelCmd   = ($urandom % 40) == 0;
      cyc("R4 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule